// File: doc/BRIEF.md
# Grouped Channel Request Arbiter

This block chooses which DMA channel a transfer engine serves next. Up to 64 channels are split into groups of equal size. A channel takes part only when its enable bit and its pending-request bit are both set. Each channel carries an 8-bit priority byte. The low nibble ranks the channel inside its group. Bits 5:4 of the byte of the first channel in each group rank that group against the other groups.

Arbitration happens in two levels: first a group, then a channel inside that group. Each level is set separately to fixed priority or to round robin through a 4-bit mode input. A decision is made only when the engine pulses its ready input. The result is registered and stays unchanged until the next pulse.

In fixed mode, duplicate ranks make the choice ambiguous. The block detects them and raises a sticky channel-level or group-level error flag. While such an error is flagged or still present, no grant is issued. Software clears the flags with a one-cycle clear pulse.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, grant_valid, grp_pri_err and ch_pri_err are 0.
- R2: Only a channel with both req_en and req_pend set can be granted. If no channel qualifies, a ready pulse gives grant_valid = 0.
- R3: The grant outputs change only on the clock edge that samples eng_ready high, and then reflect the inputs of that cycle. With eng_ready low they hold their value.
- R4: With mode_ctrl bit 3 clear, the winning group is the group with the largest value in bits 5:4 of its first channel's priority byte, among groups that hold a qualifying channel.
- R5: With mode_ctrl bit 2 clear, the winning channel is the qualifying channel in the chosen group with the largest low nibble of its priority byte.
- R6: With mode_ctrl bit 3 set, groups are searched starting one past the last granted group, wrapping modulo the group count. After reset the search starts at group 0.
- R7: With mode_ctrl bit 2 set, each group keeps its own pointer. The search starts one past that group's last granted channel and wraps within the group. After reset it starts at local index 0.
- R8: With mode_ctrl bit 2 clear, two channels of one group with equal low nibbles set ch_pri_err on the next edge. The flag stays set until an err_clear pulse arrives while no such duplicate exists. In round-robin channel mode no duplicate is reported.
- R9: With mode_ctrl bit 3 clear, two groups with equal group ranks set grp_pri_err on the next edge. The flag stays set under the same clearing rule as R8. In round-robin group mode no duplicate is reported.
- R10: While either error flag is set or a duplicate is currently detected, a ready pulse gives grant_valid = 0.
- R11: grant_ch equals group index times group size plus the local index. mode_ctrl bits 1:0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 64 | Per-channel participation enable |
| req_pend | input | 64 | Per-channel pending request |
| chan_pri | input | 512 | Priority bytes, byte i belongs to channel i |
| mode_ctrl | input | 4 | Bit 3 group round robin, bit 2 channel round robin |
| eng_ready | input | 1 | Engine ready for a new channel (pulse) |
| err_clear | input | 1 | Clears the priority error flags |
| grant_valid | output | 1 | A channel is granted |
| grant_ch | output | 6 | Granted channel index |
| grp_pri_err | output | 1 | Duplicate group rank flagged |
| ch_pri_err | output | 1 | Duplicate channel rank flagged |

## Verification
A corrupted round-robin pointer does not show up at once. It appears on the next ready pulse that reaches the affected group, as a grant to the wrong channel, so the bench tracks every pointer and compares each grant. A wrong rank comparison or a wrong group mux shows up as a wrong grant_ch one cycle after the ready pulse. A lost or stuck error flag shows up as a grant that appears or is missing one cycle after a ready pulse. Sweeps with single qualifying channels and with dense patterns cover every channel slot.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int MODE_W          = 4;
  localparam int MODE_GRP_RR_BIT = 3;
  localparam int MODE_CH_RR_BIT  = 2;
endpackage

// File: rtl/arb_dup_detect.sv
// Flags any two equal keys among N entries when enabled.
module arb_dup_detect #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic           en,
  input  logic [N*W-1:0] keys,
  output logic           dup
);
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (keys[i*W +: W] == keys[j*W +: W]) dup = 1'b1;
      end
    end
    dup = dup & en;
  end
endmodule

// File: rtl/arb_pick.sv
// One arbitration level: fixed largest-rank or round robin after a pointer.
module arb_pick #(
  parameter int N  = 16,
  parameter int RW = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*RW-1:0] rank,
  input  logic            rr_en,
  input  logic [IW-1:0]   last,
  output logic            found,
  output logic [IW-1:0]   sel
);
  logic [RW-1:0] best;
  logic [IW-1:0] idx;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    best  = '0;
    idx   = '0;
    if (rr_en) begin
      for (int k = 1; k <= N; k++) begin
        idx = last + IW'(k);
        if (!found && cand[idx]) begin
          found = 1'b1;
          sel   = idx;
        end
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cand[i] && (!found || rank[i*RW +: RW] > best)) begin
          found = 1'b1;
          sel   = IW'(i);
          best  = rank[i*RW +: RW];
        end
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int GRP_SIZE = 16,
  parameter int PRI_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         req_en,
  input  logic [NUM_CH-1:0]         req_pend,
  input  logic [NUM_CH*PRI_W-1:0]   chan_pri,
  input  logic [MODE_W-1:0]         mode_ctrl,
  input  logic                      eng_ready,
  input  logic                      err_clear,
  output logic                      grant_valid,
  output logic [$clog2(NUM_CH)-1:0] grant_ch,
  output logic                      grp_pri_err,
  output logic                      ch_pri_err
);
  localparam int NUM_GRP = NUM_CH / GRP_SIZE;
  localparam int GW      = $clog2(NUM_GRP);
  localparam int LW      = $clog2(GRP_SIZE);
  localparam int CW      = GW + LW;

  logic                              grp_rr, ch_rr;
  logic [NUM_CH-1:0]                 elig;
  logic [NUM_GRP-1:0][GRP_SIZE-1:0]  elig_g;
  logic [NUM_GRP-1:0]                grp_any;
  logic [NUM_GRP*GW-1:0]             grp_rank;
  logic [NUM_GRP-1:0][GRP_SIZE*LW-1:0] ch_rank;
  logic [NUM_GRP-1:0]                ch_dup_g;
  logic                              ch_det, grp_det, blocked;

  logic                              grp_found, ch_found;
  logic [GW-1:0]                     grp_sel;
  logic [LW-1:0]                     ch_sel;
  logic [GRP_SIZE-1:0]               sel_elig;
  logic [GRP_SIZE*LW-1:0]            sel_rank;
  logic [LW-1:0]                     sel_last;

  logic                              gv_q, gv_n;
  logic [CW-1:0]                     gch_q, gch_n;
  logic [GW-1:0]                     lg_q, lg_n;
  logic [NUM_GRP-1:0][LW-1:0]        lc_q, lc_n;
  logic                              cerr_q, cerr_n, gerr_q, gerr_n;
  logic                              gnt_en;

  assign grp_rr = mode_ctrl[MODE_GRP_RR_BIT];
  assign ch_rr  = mode_ctrl[MODE_CH_RR_BIT];
  assign elig   = req_en & req_pend;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign elig_g[g]  = elig[g*GRP_SIZE +: GRP_SIZE];
    assign grp_any[g] = |elig_g[g];
    assign grp_rank[g*GW +: GW] = chan_pri[g*GRP_SIZE*PRI_W + LW +: GW];
    for (genvar c = 0; c < GRP_SIZE; c++) begin : g_ch
      assign ch_rank[g][c*LW +: LW] = chan_pri[(g*GRP_SIZE + c)*PRI_W +: LW];
    end
    arb_dup_detect #(.N(GRP_SIZE), .W(LW)) u_ch_dup (
      .en  (~ch_rr),
      .keys(ch_rank[g]),
      .dup (ch_dup_g[g])
    );
  end

  arb_dup_detect #(.N(NUM_GRP), .W(GW)) u_grp_dup (
    .en  (~grp_rr),
    .keys(grp_rank),
    .dup (grp_det)
  );

  assign ch_det  = |ch_dup_g;
  assign blocked = cerr_q | gerr_q | ch_det | grp_det;

  arb_pick #(.N(NUM_GRP), .RW(GW)) u_grp_pick (
    .cand (grp_any),
    .rank (grp_rank),
    .rr_en(grp_rr),
    .last (lg_q),
    .found(grp_found),
    .sel  (grp_sel)
  );

  assign sel_elig = elig_g[grp_sel];
  assign sel_rank = ch_rank[grp_sel];
  assign sel_last = lc_q[grp_sel];

  arb_pick #(.N(GRP_SIZE), .RW(LW)) u_ch_pick (
    .cand (sel_elig),
    .rank (sel_rank),
    .rr_en(ch_rr),
    .last (sel_last),
    .found(ch_found),
    .sel  (ch_sel)
  );

  // next state
  assign gnt_en = eng_ready;

  always_comb begin
    gv_n   = 1'b0;
    gch_n  = gch_q;
    lg_n   = lg_q;
    lc_n   = lc_q;
    cerr_n = (cerr_q & ~err_clear) | ch_det;
    gerr_n = (gerr_q & ~err_clear) | grp_det;
    if (!blocked && grp_found && ch_found) begin
      gv_n          = 1'b1;
      gch_n         = {grp_sel, ch_sel};
      lg_n          = grp_sel;
      lc_n[grp_sel] = ch_sel;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv_q  <= 1'b0;
      gch_q <= '0;
      lg_q  <= GW'(NUM_GRP - 1);
      lc_q  <= {NUM_GRP{LW'(GRP_SIZE - 1)}};
    end else if (gnt_en) begin
      gv_q  <= gv_n;
      gch_q <= gch_n;
      lg_q  <= lg_n;
      lc_q  <= lc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cerr_q <= 1'b0;
      gerr_q <= 1'b0;
    end else begin
      cerr_q <= cerr_n;
      gerr_q <= gerr_n;
    end
  end

  assign grant_valid = gv_q;
  assign grant_ch    = gch_q;
  assign grp_pri_err = gerr_q;
  assign ch_pri_err  = cerr_q;

  // assertions
  assert_pick_qualifies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    grp_found |-> (grp_any[grp_sel] && ch_found && sel_elig[ch_sel]));

  assert_grant_on_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ready && !blocked && (|elig)) |=> grant_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_ready |=> ($stable(grant_valid) && $stable(grant_ch)));

  assert_no_qual_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ready && !(|elig)) |=> !grant_valid);

  assert_ch_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ch_det |=> ch_pri_err);

  assert_ch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pri_err && !err_clear) |=> ch_pri_err);

  assert_grp_detect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grp_det |=> grp_pri_err);

  assert_grp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_pri_err && !err_clear) |=> grp_pri_err);

  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_ready && blocked) |=> !grant_valid);
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;
  localparam int GS  = 16;
  localparam int NG  = 4;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NCH-1:0]  req_en, req_pend;
  logic [NCH*8-1:0] chan_pri;
  logic [3:0]      mode_ctrl;
  logic            eng_ready, err_clear;
  logic            grant_valid;
  logic [5:0]      grant_ch;
  logic            grp_pri_err, ch_pri_err;

  dma_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_pend(req_pend),
    .chan_pri(chan_pri), .mode_ctrl(mode_ctrl), .eng_ready(eng_ready),
    .err_clear(err_clear), .grant_valid(grant_valid), .grant_ch(grant_ch),
    .grp_pri_err(grp_pri_err), .ch_pri_err(ch_pri_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] pri_b [NCH];
  int m_lg;
  int m_lc [NG];
  logic [31:0] rs = 32'h1234_5678;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic apply_pri();
    for (int i = 0; i < NCH; i++) chan_pri[i*8 +: 8] = pri_b[i];
  endtask

  // valid permutation: local rank (l*mul+add+g)%16 with odd mul, group rank (g+rot)%4
  task automatic set_perm(input int mul, input int add, input int rot);
    for (int i = 0; i < NCH; i++) begin
      int g = i / GS;
      int l = i % GS;
      pri_b[i][3:0] = 4'((l*mul + add + g) % 16);
      pri_b[i][7:4] = 4'((i*5 + 3) % 16);
      if (l == 0) pri_b[i][5:4] = 2'((g + rot) % 4);
    end
    apply_pri();
  endtask

  task automatic expect_pick(output bit ev, output int ech);
    logic [NCH-1:0] el;
    int gsel;
    int best;
    bit f;
    el   = req_en & req_pend;
    ev   = 1'b0;
    ech  = 0;
    gsel = -1;
    if (mode_ctrl[3]) begin
      for (int k = 1; k <= NG; k++) begin
        int g = (m_lg + k) % NG;
        if (gsel < 0 && (|el[g*GS +: GS])) gsel = g;
      end
    end else begin
      best = -1;
      for (int g = 0; g < NG; g++)
        if ((|el[g*GS +: GS]) && int'(pri_b[g*GS][5:4]) > best) begin
          best = int'(pri_b[g*GS][5:4]);
          gsel = g;
        end
    end
    if (gsel < 0) return;
    f = 1'b0;
    if (mode_ctrl[2]) begin
      for (int k = 1; k <= GS; k++) begin
        int l = (m_lc[gsel] + k) % GS;
        if (!f && el[gsel*GS + l]) begin
          f = 1'b1;
          ech = gsel*GS + l;
        end
      end
    end else begin
      best = -1;
      for (int l = 0; l < GS; l++)
        if (el[gsel*GS + l] && int'(pri_b[gsel*GS + l][3:0]) > best) begin
          best = int'(pri_b[gsel*GS + l][3:0]);
          ech = gsel*GS + l;
        end
    end
    ev = 1'b1;
  endtask

  // pulse ready, compare one edge later, update model pointers
  task automatic ready_and_check(input string req);
    bit ev;
    int ech;
    expect_pick(ev, ech);
    eng_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_ready = 1'b0;
    check(req, int'(grant_valid), int'(ev));
    if (ev) begin
      check(req, int'(grant_ch), ech);
      m_lg = ech / GS;
      m_lc[ech / GS] = ech % GS;
    end
  endtask

  task automatic ready_expect_none(input string req);
    eng_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_ready = 1'b0;
    check(req, int'(grant_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_en    = '0;
    req_pend  = '0;
    mode_ctrl = 4'b0000;
    eng_ready = 1'b0;
    err_clear = 1'b0;
    set_perm(7, 0, 0);
    m_lg = NG - 1;
    for (int g = 0; g < NG; g++) m_lc[g] = GS - 1;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1", int'(grant_valid), 0);
    check("R1", int'(ch_pri_err), 0);
    check("R1", int'(grp_pri_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(grant_valid), 0);
    check("R1", int'(ch_pri_err), 0);
    check("R1", int'(grp_pri_err), 0);

    // R2: nothing qualifies
    req_en = '1;
    ready_expect_none("R2");
    req_pend = '1;
    req_en   = '0;
    ready_expect_none("R2");

    // round robin from reset starts at group 0, local 0 (R6, R7)
    req_en    = '1;
    req_pend  = '1;
    mode_ctrl = 4'b1100;
    ready_and_check("R6/R7");
    check("R6", int'(grant_ch), 0);
    ready_and_check("R7");

    // single qualifying channel per mode: R11 index mapping, R2
    for (int md = 0; md < 4; md++) begin
      mode_ctrl = {2'(md), 2'(md ^ 1)};
      for (int c = 0; c < NCH; c++) begin
        req_en   = '1;
        req_pend = '0;
        req_pend[c] = 1'b1;
        ready_and_check("R11");
      end
    end

    // masked by enable: pend set only where enable is clear
    mode_ctrl = 4'b0000;
    req_en   = {NCH/2{2'b01}};
    req_pend = {NCH/2{2'b10}};
    ready_expect_none("R2");

    // R3: hold while ready low
    req_en   = '1;
    req_pend = 64'h0000_0100_0000_0000;
    ready_and_check("R3");
    req_pend = 64'h0000_0000_0000_0001;
    repeat (3) @(negedge clk);
    check("R3", int'(grant_ch), 40);
    check("R3", int'(grant_valid), 1);

    // sweeps over modes, permutations and patterns (R4 R5 R6 R7 R11)
    for (int pm = 0; pm < 3; pm++) begin
      set_perm(2*pm + 3, pm * 5, pm + 1);
      for (int md = 0; md < 4; md++) begin
        for (int t = 0; t < 200; t++) begin
          logic [63:0] a, b;
          a = {rnd(), rnd()};
          b = {rnd(), rnd()};
          mode_ctrl = {2'(md), rnd()[1:0]};
          req_en    = (t % 3 == 0) ? '1 : a | b;
          req_pend  = (t % 2 == 0) ? (a & b & {rnd(), rnd()}) : a;
          @(negedge clk);
          case (md)
            0: ready_and_check("R4/R5");
            1: ready_and_check("R4/R7");
            2: ready_and_check("R6/R5");
            default: ready_and_check("R6/R7");
          endcase
        end
      end
    end

    // R8: duplicate channel rank in group 2
    set_perm(7, 0, 0);
    req_en    = '1;
    req_pend  = '1;
    mode_ctrl = 4'b0100;
    pri_b[37][3:0] = pri_b[38][3:0];
    apply_pri();
    @(negedge clk);
    check("R8", int'(ch_pri_err), 0);
    mode_ctrl = 4'b0000;
    @(negedge clk);
    check("R8", int'(ch_pri_err), 1);
    ready_expect_none("R10");
    mode_ctrl = 4'b0100;
    @(negedge clk);
    check("R8", int'(ch_pri_err), 1);
    ready_expect_none("R10");
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R8", int'(ch_pri_err), 0);
    ready_and_check("R10");

    // R9: duplicate group rank
    set_perm(7, 0, 0);
    mode_ctrl = 4'b1000;
    pri_b[16][5:4] = pri_b[48][5:4];
    apply_pri();
    @(negedge clk);
    check("R9", int'(grp_pri_err), 0);
    mode_ctrl = 4'b0000;
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R9", int'(grp_pri_err), 1);
    ready_expect_none("R10");
    set_perm(7, 0, 0);
    @(negedge clk);
    check("R9", int'(grp_pri_err), 1);
    ready_expect_none("R10");
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R9", int'(grp_pri_err), 0);
    ready_and_check("R10");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule